// File: doc/BRIEF.md
# Interrupt Pin Request and Delivery Logic

This block sits between a set of interrupt input lines and a downstream interrupt fabric. Each pin carries a request register bit that follows line events, and the routing settings for each pin come from an external redirection table: mask, trigger type, vector, destination, destination addressing mode and delivery type. Line events arrive as a one-cycle strobe with the new line level. A rising request on an unmasked pin produces a delivery attempt. The attempt is dropped when the pin is masked, or when a level pin is still waiting for its end-of-interrupt. An edge event on a pin that is already pending is coalesced rather than delivered again.

Eligible pins are served one at a time, lowest pin number first. The request is held in a single output register until the fabric returns a completion strobe. That strobe says whether at least one destination took the interrupt. An accepted level request sets the pin's remote request flag, which blocks further deliveries of that pin until a separate end-of-interrupt block clears it. When the table writes an entry that leaves a level pin unmasked, with a pending request and no outstanding acknowledgement, the pin is served again. Every line event returns a one-cycle status pulse that says whether the event completed normally or was coalesced.

Top module: `irq_pin_dlv`

## Requirements
- R1: A line event with level 0 clears that pin's request bit (irr), and the following cycle shows evt_ok=1 and evt_coal=0 for the pin.
- R2: A line event with level 1 sets irr. If the pin is edge-triggered (cfg_trig=0) and irr was already 1, the event is coalesced: evt_coal=1, evt_ok=0, and no request is issued.
- R3: No request is issued for a pin whose cfg_mask bit is 1, or for a level-triggered pin (cfg_trig=1) whose remote_irr bit is 1.
- R4: When the fabric completes a level-triggered request with dlv_done=1 and dlv_hit=1, remote_irr for that pin becomes 1. If dlv_hit=0 it stays 0. An eoi_clr pulse clears remote_irr.
- R5: When a request for an edge-triggered pin is issued, its edge_dlvd bit becomes 1. Any level-1 line event on that pin clears the bit, coalesced or not.
- R6: A cfg_wr pulse for a level-triggered pin that leaves it unmasked, with irr=1 and remote_irr=0, issues a new request for that pin.
- R7: A request carries the selected pin's vector, destination, destination-mode bit, delivery type and trigger type. req_short is always 0, meaning no destination shorthand. All fields and req_valid hold steady until dlv_done.
- R8: When several pins are eligible at the same time, they are issued in ascending pin order, one request per completion.
- R9: Every line event produces exactly one of evt_ok or evt_coal, in the cycle after the event. A level-1 event that is not coalesced reports evt_ok=1.
- R10: After reset, irr, remote_irr, edge_dlvd, evt_ok, evt_coal and req_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_valid | input | NPINS | One-cycle line event strobe per pin |
| line_level | input | NPINS | New line level for a strobed pin |
| cfg_mask | input | NPINS | Pin mask, 1 = masked |
| cfg_trig | input | NPINS | Trigger type, 0 = edge, 1 = level |
| cfg_wr | input | NPINS | Pulse: table entry for this pin was just written |
| cfg_vector | input | NPINS*VW | Vector per pin, pin i at bits i*VW |
| cfg_dest | input | NPINS*DW | Destination ID per pin, pin i at bits i*DW |
| cfg_dest_logical | input | NPINS | Destination mode per pin, 1 = logical |
| cfg_dlv_mode | input | NPINS*3 | Delivery type per pin, pin i at bits i*3 |
| eoi_clr | input | NPINS | Pulse: clear remote_irr of this pin |
| req_valid | output | 1 | Delivery request outstanding |
| req_pin | output | PW | Pin number of the request |
| req_vector | output | VW | Vector of the request |
| req_dest | output | DW | Destination ID of the request |
| req_dest_logical | output | 1 | Destination mode of the request |
| req_dlv_mode | output | 3 | Delivery type of the request |
| req_trig | output | 1 | Trigger type of the request |
| req_short | output | 2 | Destination shorthand, always 0 |
| dlv_done | input | 1 | Fabric completes the outstanding request |
| dlv_hit | input | 1 | With dlv_done: at least one destination accepted |
| irr | output | NPINS | Request register bits |
| remote_irr | output | NPINS | Level acknowledgement outstanding per pin |
| edge_dlvd | output | NPINS | Edge pin delivered flag |
| evt_ok | output | NPINS | Status pulse: event completed, not coalesced |
| evt_coal | output | NPINS | Status pulse: event coalesced |

## Verification
The status pulses and the new request bit appear one cycle after a line event is sampled. A resulting request appears one cycle later, two cycles after the event, together with the edge delivered flag. A completion strobe clears req_valid and updates remote_irr in the very next cycle. The next queued pin is issued one cycle after that, because a request loads only into an empty register. The bench drives every stimulus just after a falling edge, steps exactly that many rising edges, and samples at the following falling edge. It also checks the in-between cycles where nothing may change, such as the cycle after a masked or blocked event where no request may appear.

// File: rtl/irq_dlv_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt pin delivery block.
// Assumes a three-bit delivery type and a two-bit shorthand field downstream.
package irq_dlv_pkg;
    localparam int DLV_W = 3;
    localparam int SHORT_W = 2;
    localparam logic [SHORT_W-1:0] SHORT_NONE = 2'b00;
    typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/irq_pin_state.sv
`timescale 1ns/1ps
// Per-pin state: request bit, remote acknowledgement flag, edge delivered
// flag, pending service flag and the event status pulses.
// Assumes the line events are one-cycle strobes and the table config is stable
// in the cycle it is sampled.
module irq_pin_state
    import irq_dlv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_valid,
    input  logic evt_level,
    input  logic cfg_mask,
    input  logic cfg_level_trig,
    input  logic cfg_wr,
    input  logic eoi_clr,
    input  logic grant,
    input  logic inflight,
    input  logic accept_hit,
    output logic irr,
    output logic remote_irr,
    output logic delivered,
    output logic svc_want,
    output logic evt_ok,
    output logic evt_coal
);
    logic svc_pend;
    logic is_assert;
    logic coal_now;
    logic reeval;

    // Event decode, coalesce detection, unmask re-evaluation, eligibility.
    always_comb begin
        is_assert = evt_valid & evt_level;
        coal_now  = is_assert & (cfg_level_trig == TRIG_EDGE) & irr;
        reeval    = cfg_wr & cfg_level_trig & ~cfg_mask & irr & ~remote_irr;
        svc_want  = svc_pend & ~cfg_mask & ~(cfg_level_trig & remote_irr) & ~inflight;
    end

    // Request bit follows the level carried by each event.
    always_ff @(posedge clk) begin
        if (!rst_n)         irr <= 1'b0;
        else if (evt_valid) irr <= evt_level;
    end

    // Pending service: set by a fresh assertion or re-evaluation, cleared by grant or drop.
    always_ff @(posedge clk) begin
        if (!rst_n)                             svc_pend <= 1'b0;
        else if ((is_assert & ~coal_now) | reeval) svc_pend <= 1'b1;
        else if (grant | (~svc_want & ~inflight)) svc_pend <= 1'b0;
    end

    // Remote acknowledgement: set on an accepted level request, cleared by end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)          remote_irr <= 1'b0;
        else if (accept_hit) remote_irr <= 1'b1;
        else if (eoi_clr)    remote_irr <= 1'b0;
    end

    // Edge delivered flag: cleared by any assertion, set when an edge request issues.
    always_ff @(posedge clk) begin
        if (!rst_n)                            delivered <= 1'b0;
        else if (is_assert & ~cfg_level_trig)  delivered <= 1'b0;
        else if (grant & ~cfg_level_trig)      delivered <= 1'b1;
    end

    // Status pulses, one cycle after each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_ok   <= 1'b0;
            evt_coal <= 1'b0;
        end else begin
            evt_ok   <= evt_valid & ~coal_now;
            evt_coal <= coal_now;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker: the lowest-numbered requesting pin wins.
// Assumes N >= 2.
module irq_prio_pick #(
    parameter int N  = 8,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0]  want,
    output logic          any,
    output logic [PW-1:0] idx,
    output logic [N-1:0]  onehot
);
    // Scan downward so the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        any = |want;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i]) idx = PW'(i);
        end
        onehot = any ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/irq_req_reg.sv
`timescale 1ns/1ps
// Single outstanding delivery request register with a completion handshake.
// Assumes load is only raised while the register is empty.
module irq_req_reg
    import irq_dlv_pkg::*;
#(
    parameter int PW = 3,
    parameter int VW = 8,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PW-1:0]    ld_pin,
    input  logic [VW-1:0]    ld_vector,
    input  logic [DW-1:0]    ld_dest,
    input  logic             ld_logical,
    input  logic [DLV_W-1:0] ld_dlv,
    input  logic             ld_trig,
    input  logic             done,
    output logic             valid,
    output logic [PW-1:0]    pin,
    output logic [VW-1:0]    vector,
    output logic [DW-1:0]    dest,
    output logic             logical,
    output logic [DLV_W-1:0] dlv,
    output logic             trig
);
    // Capture on load, release on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            pin     <= '0;
            vector  <= '0;
            dest    <= '0;
            logical <= 1'b0;
            dlv     <= '0;
            trig    <= 1'b0;
        end else if (load) begin
            valid   <= 1'b1;
            pin     <= ld_pin;
            vector  <= ld_vector;
            dest    <= ld_dest;
            logical <= ld_logical;
            dlv     <= ld_dlv;
            trig    <= ld_trig;
        end else if (done) begin
            valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pin_dlv.sv
`timescale 1ns/1ps
// Interrupt pin request and delivery: per-pin request state, lowest-index
// arbitration and one outstanding request toward the interrupt fabric.
// Assumes the redirection table is held outside and end-of-interrupt
// processing drives eoi_clr.
module irq_pin_dlv
    import irq_dlv_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int VW    = 8,
    parameter int DW    = 8,
    parameter int PW    = $clog2(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPINS-1:0]       line_valid,
    input  logic [NPINS-1:0]       line_level,
    input  logic [NPINS-1:0]       cfg_mask,
    input  logic [NPINS-1:0]       cfg_trig,
    input  logic [NPINS-1:0]       cfg_wr,
    input  logic [NPINS*VW-1:0]    cfg_vector,
    input  logic [NPINS*DW-1:0]    cfg_dest,
    input  logic [NPINS-1:0]       cfg_dest_logical,
    input  logic [NPINS*DLV_W-1:0] cfg_dlv_mode,
    input  logic [NPINS-1:0]       eoi_clr,
    output logic                   req_valid,
    output logic [PW-1:0]          req_pin,
    output logic [VW-1:0]          req_vector,
    output logic [DW-1:0]          req_dest,
    output logic                   req_dest_logical,
    output logic [DLV_W-1:0]       req_dlv_mode,
    output logic                   req_trig,
    output logic [SHORT_W-1:0]     req_short,
    input  logic                   dlv_done,
    input  logic                   dlv_hit,
    output logic [NPINS-1:0]       irr,
    output logic [NPINS-1:0]       remote_irr,
    output logic [NPINS-1:0]       edge_dlvd,
    output logic [NPINS-1:0]       evt_ok,
    output logic [NPINS-1:0]       evt_coal
);
    logic [NPINS-1:0] want;
    logic [NPINS-1:0] pick_oh;
    logic [NPINS-1:0] grant;
    logic [NPINS-1:0] inflight;
    logic [NPINS-1:0] accept_hit;
    logic             pick_any;
    logic [PW-1:0]    pick_idx;
    logic             load;
    logic [VW-1:0]    sel_vector;
    logic [DW-1:0]    sel_dest;
    logic [DLV_W-1:0] sel_dlv;

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        // Per-pin routing of grant, in-flight and acceptance.
        assign inflight[gi]   = req_valid & (req_pin == PW'(gi));
        assign accept_hit[gi] = dlv_done & dlv_hit & req_trig & inflight[gi];

        irq_pin_state u_state (
            .clk            (clk),
            .rst_n          (rst_n),
            .evt_valid      (line_valid[gi]),
            .evt_level      (line_level[gi]),
            .cfg_mask       (cfg_mask[gi]),
            .cfg_level_trig (cfg_trig[gi]),
            .cfg_wr         (cfg_wr[gi]),
            .eoi_clr        (eoi_clr[gi]),
            .grant          (grant[gi]),
            .inflight       (inflight[gi]),
            .accept_hit     (accept_hit[gi]),
            .irr            (irr[gi]),
            .remote_irr     (remote_irr[gi]),
            .delivered      (edge_dlvd[gi]),
            .svc_want       (want[gi]),
            .evt_ok         (evt_ok[gi]),
            .evt_coal       (evt_coal[gi])
        );
    end

    irq_prio_pick #(.N(NPINS), .PW(PW)) u_pick (
        .want   (want),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    // Load when the output register is empty; select the winner's fields.
    always_comb begin
        load       = pick_any & ~req_valid;
        grant      = pick_oh & {NPINS{load}};
        sel_vector = cfg_vector[pick_idx*VW +: VW];
        sel_dest   = cfg_dest[pick_idx*DW +: DW];
        sel_dlv    = cfg_dlv_mode[pick_idx*DLV_W +: DLV_W];
    end

    irq_req_reg #(.PW(PW), .VW(VW), .DW(DW)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .ld_pin     (pick_idx),
        .ld_vector  (sel_vector),
        .ld_dest    (sel_dest),
        .ld_logical (cfg_dest_logical[pick_idx]),
        .ld_dlv     (sel_dlv),
        .ld_trig    (cfg_trig[pick_idx]),
        .done       (dlv_done),
        .valid      (req_valid),
        .pin        (req_pin),
        .vector     (req_vector),
        .dest       (req_dest),
        .logical    (req_dest_logical),
        .dlv        (req_dlv_mode),
        .trig       (req_trig)
    );

    // Requests never use a destination shorthand.
    assign req_short = SHORT_NONE;
endmodule

// File: rtl/irq_pin_dlv_chk.sv
`timescale 1ns/1ps
// Protocol checker for irq_pin_dlv, attached with bind below.
// Assumes the same parameter values as the checked instance.
module irq_pin_dlv_chk #(
    parameter int NPINS = 8,
    parameter int VW    = 8,
    parameter int PW    = $clog2(NPINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] line_valid,
    input logic [NPINS-1:0] line_level,
    input logic [NPINS-1:0] cfg_mask,
    input logic             dlv_done,
    input logic             dlv_hit,
    input logic             req_valid,
    input logic [PW-1:0]    req_pin,
    input logic [VW-1:0]    req_vector,
    input logic             req_trig,
    input logic [NPINS-1:0] remote_irr,
    input logic [NPINS-1:0] edge_dlvd,
    input logic [NPINS-1:0] evt_coal
);
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] remote_q;

    // Previous-cycle copies of mask and remote flags for load-time checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '1;
            remote_q <= '0;
        end else begin
            mask_q   <= cfg_mask;
            remote_q <= remote_irr;
        end
    end

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !dlv_done |=> req_valid && $stable(req_pin) && $stable(req_vector));

    p_mask_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> !mask_q[req_pin]);

    p_remote_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) && req_trig |-> !remote_q[req_pin]);

    p_remote_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(remote_irr & ~$past(remote_irr))) |-> $past(dlv_done && dlv_hit && req_valid && req_trig));

    p_coal_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_coal) |-> ((evt_coal & ~$past(line_valid & line_level)) == '0));

    p_dlvd_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(edge_dlvd & ~$past(edge_dlvd))) |-> $rose(req_valid) && !req_trig);
endmodule

bind irq_pin_dlv irq_pin_dlv_chk #(.NPINS(NPINS), .VW(VW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_valid (line_valid),
    .line_level (line_level),
    .cfg_mask   (cfg_mask),
    .dlv_done   (dlv_done),
    .dlv_hit    (dlv_hit),
    .req_valid  (req_valid),
    .req_pin    (req_pin),
    .req_vector (req_vector),
    .req_trig   (req_trig),
    .remote_irr (remote_irr),
    .edge_dlvd  (edge_dlvd),
    .evt_coal   (evt_coal)
);

// File: tb/irq_pin_dlv_bench.sv
`timescale 1ns/1ps
// Sweep bench: every pin under edge/level and masked/unmasked settings,
// then a same-cycle burst on all pins to check issue order.
module irq_pin_dlv_bench;
    localparam int NPINS = 8;
    localparam int VW    = 8;
    localparam int DW    = 8;
    localparam int PW    = $clog2(NPINS);

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NPINS-1:0]     line_valid, line_level, cfg_mask, cfg_trig, cfg_wr;
    logic [NPINS*VW-1:0]  cfg_vector;
    logic [NPINS*DW-1:0]  cfg_dest;
    logic [NPINS-1:0]     cfg_dest_logical;
    logic [NPINS*3-1:0]   cfg_dlv_mode;
    logic [NPINS-1:0]     eoi_clr;
    logic                 req_valid, req_dest_logical, req_trig, dlv_done, dlv_hit;
    logic [PW-1:0]        req_pin;
    logic [VW-1:0]        req_vector;
    logic [DW-1:0]        req_dest;
    logic [2:0]           req_dlv_mode;
    logic [1:0]           req_short;
    logic [NPINS-1:0]     irr, remote_irr, edge_dlvd, evt_ok, evt_coal;

    int n_chk = 0;
    int n_fail = 0;
    bit fin = 1'b0;

    always #4 clk = ~clk;

    irq_pin_dlv #(.NPINS(NPINS), .VW(VW), .DW(DW)) u_irq_pin_dlv (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_level(line_level),
        .cfg_mask(cfg_mask), .cfg_trig(cfg_trig), .cfg_wr(cfg_wr),
        .cfg_vector(cfg_vector), .cfg_dest(cfg_dest), .cfg_dest_logical(cfg_dest_logical),
        .cfg_dlv_mode(cfg_dlv_mode), .eoi_clr(eoi_clr), .req_valid(req_valid),
        .req_pin(req_pin), .req_vector(req_vector), .req_dest(req_dest),
        .req_dest_logical(req_dest_logical), .req_dlv_mode(req_dlv_mode),
        .req_trig(req_trig), .req_short(req_short), .dlv_done(dlv_done),
        .dlv_hit(dlv_hit), .irr(irr), .remote_irr(remote_irr), .edge_dlvd(edge_dlvd),
        .evt_ok(evt_ok), .evt_coal(evt_coal)
    );

    function automatic logic [VW-1:0] exp_vec(int p);  return VW'(8'h30 + p * 5); endfunction
    function automatic logic [DW-1:0] exp_dest(int p); return DW'((p * 9) ^ 8'h80); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic evt(input int p, input logic lvl);
        line_valid[p] = 1'b1;
        line_level[p] = lvl;
        cyc();
        line_valid = '0;
    endtask

    task automatic done(input logic hit);
        dlv_done = 1'b1;
        dlv_hit  = hit;
        cyc();
        dlv_done = 1'b0;
        dlv_hit  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        line_valid = '0; line_level = '0; cfg_mask = '1; cfg_trig = '0; cfg_wr = '0;
        eoi_clr = '0; dlv_done = 1'b0; dlv_hit = 1'b0;
        for (int p = 0; p < NPINS; p++) begin
            cfg_vector[p*VW +: VW] = exp_vec(p);
            cfg_dest[p*DW +: DW]   = exp_dest(p);
            cfg_dest_logical[p]    = p[0];
            cfg_dlv_mode[p*3 +: 3] = p[2:0];
        end
        repeat (3) cyc();
        // R10: reset state
        chk("R10 irr", 32'(irr), 0);
        chk("R10 remote_irr", 32'(remote_irr), 0);
        chk("R10 edge_dlvd", 32'(edge_dlvd), 0);
        chk("R10 status", 32'({evt_ok, evt_coal}), 0);
        chk("R10 req_valid", 32'(req_valid), 0);
        rst_n = 1'b1;
        cyc();

        for (int p = 0; p < NPINS; p++) begin
            for (int t = 0; t < 2; t++) begin
                for (int m = 0; m < 2; m++) begin
                    cfg_trig[p] = t[0];
                    cfg_mask[p] = m[0];
                    evt(p, 1'b1);
                    chk("R2 irr set", 32'(irr[p]), 1);
                    chk("R9 ok pulse", 32'(evt_ok[p]), 1);
                    chk("R9 no coal", 32'(evt_coal[p]), 0);
                    if (t == 0) chk("R5 cleared by assertion", 32'(edge_dlvd[p]), 0);
                    cyc();
                    if (m == 1) begin
                        chk("R3 masked no request", 32'(req_valid), 0);
                        if (t == 1) begin
                            // R6: unmask write re-services a pending level pin
                            cfg_mask[p] = 1'b0;
                            cfg_wr[p] = 1'b1;
                            cyc();
                            cfg_wr = '0;
                            cyc();
                            chk("R6 request after unmask", 32'(req_valid), 1);
                            chk("R6 request pin", 32'(req_pin), 32'(p));
                            done(1'b0);
                            chk("R4 no hit keeps remote clear", 32'(remote_irr[p]), 0);
                        end
                        evt(p, 1'b0);
                        chk("R1 irr cleared", 32'(irr[p]), 0);
                        chk("R1 ok pulse", 32'(evt_ok[p]), 1);
                    end else begin
                        chk("R7 request valid", 32'(req_valid), 1);
                        chk("R7 pin", 32'(req_pin), 32'(p));
                        chk("R7 vector", 32'(req_vector), 32'(exp_vec(p)));
                        chk("R7 dest", 32'(req_dest), 32'(exp_dest(p)));
                        chk("R7 dest mode", 32'(req_dest_logical), 32'(p[0]));
                        chk("R7 delivery type", 32'(req_dlv_mode), 32'(p[2:0]));
                        chk("R7 trigger", 32'(req_trig), 32'(t));
                        chk("R7 shorthand", 32'(req_short), 0);
                        chk("R5 delivered flag", 32'(edge_dlvd[p]), 32'(t == 0));
                        cyc();
                        chk("R7 held", 32'({req_valid, 4'(req_pin)}), 32'({1'b1, 4'(p)}));
                        done(1'b1);
                        chk("R7 released", 32'(req_valid), 0);
                        chk("R4 remote after accept", 32'(remote_irr[p]), 32'(t));
                        if (t == 0) begin
                            evt(p, 1'b1);
                            chk("R2 coalesced", 32'({evt_ok[p], evt_coal[p]}), 32'(2'b01));
                            chk("R5 coalesced assertion clears", 32'(edge_dlvd[p]), 0);
                            cyc();
                            chk("R2 no request on coalesce", 32'(req_valid), 0);
                            evt(p, 1'b0);
                            chk("R1 irr cleared", 32'(irr[p]), 0);
                            chk("R1 status", 32'({evt_ok[p], evt_coal[p]}), 32'(2'b10));
                        end else begin
                            evt(p, 1'b1);
                            chk("R9 level not coalesced", 32'({evt_ok[p], evt_coal[p]}), 32'(2'b10));
                            cyc();
                            chk("R3 remote blocks", 32'(req_valid), 0);
                            eoi_clr[p] = 1'b1;
                            cyc();
                            eoi_clr = '0;
                            chk("R4 eoi clears remote", 32'(remote_irr[p]), 0);
                            cyc();
                            chk("R3 dropped attempt stays dropped", 32'(req_valid), 0);
                            evt(p, 1'b0);
                            chk("R1 irr cleared", 32'(irr[p]), 0);
                        end
                    end
                    cfg_mask[p] = 1'b1;
                    cfg_trig[p] = 1'b0;
                    cyc();
                end
            end
        end

        // R8: all pins edge, unmasked, asserted together
        cfg_mask = '0;
        cfg_trig = '0;
        line_valid = '1;
        line_level = '1;
        cyc();
        line_valid = '0;
        cyc();
        for (int k = 0; k < NPINS; k++) begin
            chk("R8 request present", 32'(req_valid), 1);
            chk("R8 ascending pin", 32'(req_pin), 32'(k));
            chk("R8 vector of pin", 32'(req_vector), 32'(exp_vec(k)));
            done(1'b1);
            chk("R8 one per completion", 32'(req_valid), 0);
            cyc();
        end
        chk("R8 queue drained", 32'(req_valid), 0);
        chk("R5 all delivered", 32'(edge_dlvd), 32'({NPINS{1'b1}}));
        line_valid = '1;
        line_level = '0;
        cyc();
        line_valid = '0;
        chk("R1 all cleared", 32'(irr), 0);

        fin = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule